// File: doc/BRIEF.md
# Chopper and Dither Signal Generator

This block derives every modulation control signal for a pair of converter channels, one carrying current and one carrying voltage, from a single measurement clock. Each channel gets a slow chopper square wave, a fast chopper square wave, a gated pseudo-random dither bit and a self-test toggle signal. The chopper rates come from one free-running binary counter. Each rate is picked by a 3-bit code from a table of divide ratios that belongs to that chopper. Codes the table leaves unused fall back onto legal rates.

Configuration arrives as plain per-channel fields: an enable and a rate code for each chopper, a dither enable and a self-test enable. A new rate code is taken only when the shared counter wraps, so a rate change never cuts a half period short. Dither comes from two 15-bit maximal-length shift registers, one per channel. Each has its own seed, and both advance on every clock.

With the default parameters the counter is 10 bits wide, so the longest period is 1024 clocks.

Top module: `chop_dither_gen`

## Requirements
- R1: While reset is asserted, and until the shared counter first wraps after reset, both rate selections of each channel act as code 000. The counter restarts at 0 two clock edges after reset is released, and the chopper and self-test outputs are 0 during reset.
- R2: Slow chopper codes 000, 001, 010, 011 and 100 give periods of 1024, 512, 256, 128 and 64 clocks. The output equals counter bit 9, 8, 7, 6 or 5: low for the first half of each period and high for the second half.
- R3: Slow chopper codes 101, 110 and 111 all give the 64-clock period (counter bit 5).
- R4: Fast chopper codes 010 through 111 give periods of 256, 128, 64, 32, 16 and 8 clocks (counter bits 7 down to 2).
- R5: Fast chopper code 000 behaves as 010 (256 clocks, bit 7), and code 001 behaves as 011 (128 clocks, bit 6).
- R6: A rate code is sampled only in the cycle where the counter holds its all-ones value. It takes effect from counter value 0 onward, and rate codes applied at any other time have no effect until then.
- R7: A chopper or dither output whose enable is 0 is 0 in that same cycle. Enabling it shows the running waveform at once, with no restart of the counter.
- R8: Each channel's dither register is 15 bits wide. On every clock after reset release it shifts left by one, taking bit14 XOR bit13 into bit 0, whether or not dither is enabled. The dither output is bit 14 ANDed with the enable. The reset seeds are 0x1ACE for the current channel and 0x6B35 for the voltage channel.
- R9: A channel's self-test output is 0 while its enable is 0. While enabled, it inverts one clock after each rising edge of that channel's ungated slow chopper square wave. This happens even when the slow chopper output itself is disabled.
- R10: The two channels are independent. Their configuration fields affect only their own outputs, and their dither bit streams differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cur_lf_en_i | input | 1 | Current channel slow chopper enable |
| cur_lf_rate_i | input | 3 | Current channel slow chopper rate code |
| cur_hf_en_i | input | 1 | Current channel fast chopper enable |
| cur_hf_rate_i | input | 3 | Current channel fast chopper rate code |
| cur_prs_en_i | input | 1 | Current channel dither enable |
| cur_bist_en_i | input | 1 | Current channel self-test enable |
| vlt_lf_en_i | input | 1 | Voltage channel slow chopper enable |
| vlt_lf_rate_i | input | 3 | Voltage channel slow chopper rate code |
| vlt_hf_en_i | input | 1 | Voltage channel fast chopper enable |
| vlt_hf_rate_i | input | 3 | Voltage channel fast chopper rate code |
| vlt_prs_en_i | input | 1 | Voltage channel dither enable |
| vlt_bist_en_i | input | 1 | Voltage channel self-test enable |
| cur_lf_o | output | 1 | Current channel slow chopper |
| cur_hf_o | output | 1 | Current channel fast chopper |
| cur_prs_o | output | 1 | Current channel dither bit |
| cur_bist_o | output | 1 | Current channel self-test toggle |
| vlt_lf_o | output | 1 | Voltage channel slow chopper |
| vlt_hf_o | output | 1 | Voltage channel fast chopper |
| vlt_prs_o | output | 1 | Voltage channel dither bit |
| vlt_bist_o | output | 1 | Voltage channel self-test toggle |

## Verification
The embedded properties assume that configuration fields and enables change only between clock edges. They assume no other timing relation: a rate code or enable may move in any cycle, including the wrap cycle. The stimulus updates every field on the falling clock edge and deliberately lands rate changes in the middle of a counter period. The properties also assume reset is asserted once from time zero. The stimulus does exactly that, and never asserts reset again.

// File: rtl/chopgen_pkg.sv
package chopgen_pkg;

  localparam int unsigned RATE_W = 3;
  typedef logic [RATE_W-1:0] rate_t;

  // Non-zero reset seeds for the two dither registers
  localparam logic [14:0] CUR_SEED = 15'h1ACE;
  localparam logic [14:0] VLT_SEED = 15'h6B35;

  // Counter bit driving the slow chopper; codes with the top bit set alias to the fastest slow rate
  function automatic int unsigned lf_tap(input rate_t code, input int unsigned cnt_w);
    if (code[2]) return cnt_w - 32'd5;
    return cnt_w - 32'd1 - {29'd0, code};
  endfunction

  // Counter bit driving the fast chopper; codes 000 and 001 alias to 010 and 011
  function automatic int unsigned hf_tap(input rate_t code, input int unsigned cnt_w);
    if (code[2:1] == 2'b00) return cnt_w - 32'd3 - {31'd0, code[0]};
    return cnt_w - 32'd1 - {29'd0, code};
  endfunction

endpackage

// File: rtl/chopgen_divider.sv
module chopgen_divider #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = &cnt_q;

  // R2: the shared count advances by exactly one per clock, wrapping naturally
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/chopgen_lfsr.sv
module chopgen_lfsr #(
  parameter int unsigned      W    = 15,
  parameter logic [W-1:0]     SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bit_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = {state_q[W-2:0], state_q[W-1] ^ state_q[W-2]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign bit_o = state_q[W-1];

  // R8: a maximal-length register never falls into the all-zero lock-up state
  assert_lfsr_live_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |-> state_q != '0);

endmodule

// File: rtl/chopgen_channel.sv
module chopgen_channel
  import chopgen_pkg::*;
#(
  parameter int unsigned       CNT_W  = 10,
  parameter int unsigned       LFSR_W = 15,
  parameter logic [LFSR_W-1:0] SEED   = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic             lf_en_i,
  input  logic [RATE_W-1:0] lf_rate_i,
  input  logic             hf_en_i,
  input  logic [RATE_W-1:0] hf_rate_i,
  input  logic             prs_en_i,
  input  logic             bist_en_i,
  output logic             lf_o,
  output logic             hf_o,
  output logic             prs_o,
  output logic             bist_o
);

  localparam int unsigned IDX_W = $clog2(CNT_W);

  rate_t            lf_sel_q, lf_sel_d;
  rate_t            hf_sel_q, hf_sel_d;
  logic [IDX_W-1:0] lf_idx, hf_idx;
  logic             lf_raw, hf_raw, lf_rise;
  logic             lf_prev_q, lf_prev_d;
  logic             bist_q, bist_d;
  logic             sel_load;
  logic             dither_bit;

  // Rate codes are only taken at the counter wrap
  assign sel_load = wrap_i;

  always_comb begin
    lf_sel_d = lf_sel_q;
    hf_sel_d = hf_sel_q;
    if (sel_load) begin
      lf_sel_d = lf_rate_i;
      hf_sel_d = hf_rate_i;
    end
    lf_idx    = IDX_W'(lf_tap(lf_sel_q, CNT_W));
    hf_idx    = IDX_W'(hf_tap(hf_sel_q, CNT_W));
    lf_raw    = cnt_i[lf_idx];
    hf_raw    = cnt_i[hf_idx];
    lf_rise   = lf_raw & ~lf_prev_q;
    lf_prev_d = lf_raw;
    bist_d    = bist_en_i ? (bist_q ^ lf_rise) : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lf_sel_q  <= '0;
      hf_sel_q  <= '0;
      lf_prev_q <= 1'b0;
      bist_q    <= 1'b0;
    end else begin
      lf_sel_q  <= lf_sel_d;
      hf_sel_q  <= hf_sel_d;
      lf_prev_q <= lf_prev_d;
      bist_q    <= bist_d;
    end
  end

  chopgen_lfsr #(
    .W    (LFSR_W),
    .SEED (SEED)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_o  (dither_bit)
  );

  assign lf_o   = lf_en_i  & lf_raw;
  assign hf_o   = hf_en_i  & hf_raw;
  assign prs_o  = prs_en_i & dither_bit;
  assign bist_o = bist_q;

  // R6: selections hold outside the wrap cycle
  assert_sel_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && !wrap_i) |=> ($stable(lf_sel_q) && $stable(hf_sel_q)));

  // R9: a disabled self-test output is low on the following cycle
  assert_bist_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && !bist_en_i) |=> !bist_o);

  // R9: while enabled, the toggle only moves after a slow chopper rising edge
  assert_bist_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && bist_en_i && !lf_rise) |=> $stable(bist_o));

endmodule

// File: rtl/chop_dither_gen.sv
module chop_dither_gen
  import chopgen_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned LFSR_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cur_lf_en_i,
  input  logic [2:0] cur_lf_rate_i,
  input  logic       cur_hf_en_i,
  input  logic [2:0] cur_hf_rate_i,
  input  logic       cur_prs_en_i,
  input  logic       cur_bist_en_i,
  input  logic       vlt_lf_en_i,
  input  logic [2:0] vlt_lf_rate_i,
  input  logic       vlt_hf_en_i,
  input  logic [2:0] vlt_hf_rate_i,
  input  logic       vlt_prs_en_i,
  input  logic       vlt_bist_en_i,
  output logic       cur_lf_o,
  output logic       cur_hf_o,
  output logic       cur_prs_o,
  output logic       cur_bist_o,
  output logic       vlt_lf_o,
  output logic       vlt_hf_o,
  output logic       vlt_prs_o,
  output logic       vlt_bist_o
);

  localparam int unsigned N_CH = 2;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  chopgen_divider #(.CNT_W(CNT_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  logic [N_CH-1:0]             lf_en_v, hf_en_v, prs_en_v, bist_en_v;
  logic [N_CH-1:0][RATE_W-1:0] lf_rate_v, hf_rate_v;
  logic [N_CH-1:0]             lf_v, hf_v, prs_v, bist_v;

  assign lf_en_v   = {vlt_lf_en_i,   cur_lf_en_i};
  assign hf_en_v   = {vlt_hf_en_i,   cur_hf_en_i};
  assign prs_en_v  = {vlt_prs_en_i,  cur_prs_en_i};
  assign bist_en_v = {vlt_bist_en_i, cur_bist_en_i};
  assign lf_rate_v = {vlt_lf_rate_i, cur_lf_rate_i};
  assign hf_rate_v = {vlt_hf_rate_i, cur_hf_rate_i};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam logic [LFSR_W-1:0] CH_SEED = (ch == 0) ? LFSR_W'(CUR_SEED) : LFSR_W'(VLT_SEED);
    chopgen_channel #(
      .CNT_W  (CNT_W),
      .LFSR_W (LFSR_W),
      .SEED   (CH_SEED)
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_int_n),
      .cnt_i     (cnt),
      .wrap_i    (wrap),
      .lf_en_i   (lf_en_v[ch]),
      .lf_rate_i (lf_rate_v[ch]),
      .hf_en_i   (hf_en_v[ch]),
      .hf_rate_i (hf_rate_v[ch]),
      .prs_en_i  (prs_en_v[ch]),
      .bist_en_i (bist_en_v[ch]),
      .lf_o      (lf_v[ch]),
      .hf_o      (hf_v[ch]),
      .prs_o     (prs_v[ch]),
      .bist_o    (bist_v[ch])
    );
  end

  assign cur_lf_o   = lf_v[0];
  assign cur_hf_o   = hf_v[0];
  assign cur_prs_o  = prs_v[0];
  assign cur_bist_o = bist_v[0];
  assign vlt_lf_o   = lf_v[1];
  assign vlt_hf_o   = hf_v[1];
  assign vlt_prs_o  = prs_v[1];
  assign vlt_bist_o = bist_v[1];

  // R1: the internal reset stays asserted for at least one edge after the pin releases
  assert_rst_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_sync_q[0]) |-> !rst_int_n);

endmodule

// File: tb/chop_dither_gen_tb.sv
module chop_dither_gen_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       en_lf [2];
  logic       en_hf [2];
  logic       en_prs [2];
  logic       en_bist [2];
  logic [2:0] rt_lf [2];
  logic [2:0] rt_hf [2];
  logic       o_lf [2];
  logic       o_hf [2];
  logic       o_prs [2];
  logic       o_bist [2];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Bench-side model state
  logic [9:0]  m_cnt;
  logic [2:0]  m_lsel [2];
  logic [2:0]  m_hsel [2];
  logic [14:0] m_lfsr [2];
  logic        m_prev [2];
  logic        m_bist [2];
  logic        m_s1, m_s2;

  chop_dither_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cur_lf_en_i(en_lf[0]), .cur_lf_rate_i(rt_lf[0]), .cur_hf_en_i(en_hf[0]), .cur_hf_rate_i(rt_hf[0]),
    .cur_prs_en_i(en_prs[0]), .cur_bist_en_i(en_bist[0]),
    .vlt_lf_en_i(en_lf[1]), .vlt_lf_rate_i(rt_lf[1]), .vlt_hf_en_i(en_hf[1]), .vlt_hf_rate_i(rt_hf[1]),
    .vlt_prs_en_i(en_prs[1]), .vlt_bist_en_i(en_bist[1]),
    .cur_lf_o(o_lf[0]), .cur_hf_o(o_hf[0]), .cur_prs_o(o_prs[0]), .cur_bist_o(o_bist[0]),
    .vlt_lf_o(o_lf[1]), .vlt_hf_o(o_hf[1]), .vlt_prs_o(o_prs[1]), .vlt_bist_o(o_bist[1])
  );

  // Rate tables as written in R2..R5
  function automatic int lf_bit(input logic [2:0] c);
    case (c)
      3'd0: return 9;
      3'd1: return 8;
      3'd2: return 7;
      3'd3: return 6;
      default: return 5;
    endcase
  endfunction

  function automatic int hf_bit(input logic [2:0] c);
    case (c)
      3'd0: return 7;
      3'd1: return 6;
      3'd2: return 7;
      3'd3: return 6;
      3'd4: return 5;
      3'd5: return 4;
      3'd6: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic model_state_reset();
    m_cnt = '0;
    for (int c = 0; c < 2; c++) begin
      m_lsel[c] = 3'd0;
      m_hsel[c] = 3'd0;
      m_prev[c] = 1'b0;
      m_bist[c] = 1'b0;
    end
    m_lfsr[0] = 15'h1ACE;
    m_lfsr[1] = 15'h6B35;
  endtask

  task automatic model_edge();
    if (!m_s2) begin
      model_state_reset();
    end else begin
      for (int c = 0; c < 2; c++) begin
        logic raw;
        raw = m_cnt[lf_bit(m_lsel[c])];
        m_bist[c] = en_bist[c] ? (m_bist[c] ^ (raw & ~m_prev[c])) : 1'b0;
        m_prev[c] = raw;
        if (m_cnt == 10'h3FF) begin
          m_lsel[c] = rt_lf[c];
          m_hsel[c] = rt_hf[c];
        end
        m_lfsr[c] = {m_lfsr[c][13:0], m_lfsr[c][14] ^ m_lfsr[c][13]};
      end
      m_cnt = m_cnt + 10'd1;
    end
    m_s2 = m_s1;
    m_s1 = rst_n;
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic compare(input string tag);
    for (int c = 0; c < 2; c++) begin
      string nm;
      nm = (c == 0) ? "cur" : "vlt";
      chk(tag, {nm, " lf"},   o_lf[c],   en_lf[c]  & m_cnt[lf_bit(m_lsel[c])]);
      chk(tag, {nm, " hf"},   o_hf[c],   en_hf[c]  & m_cnt[hf_bit(m_hsel[c])]);
      chk(tag, {nm, " prs"},  o_prs[c],  en_prs[c] & m_lfsr[c][14]);
      chk(tag, {nm, " bist"}, o_bist[c], m_bist[c]);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic set_ch(input int c, input logic lfe, input logic [2:0] lfr, input logic hfe,
                        input logic [2:0] hfr, input logic pe, input logic be);
    en_lf[c] = lfe; rt_lf[c] = lfr; en_hf[c] = hfe; rt_hf[c] = hfr; en_prs[c] = pe; en_bist[c] = be;
  endtask

  task automatic wait_cnt(input logic [9:0] v, input string tag);
    while (m_cnt != v) tick(tag);
  endtask

  // R1: reset state and initial selections
  task automatic t_reset();
    rst_n = 1'b0;
    set_ch(0, 1, 3'd3, 1, 3'd5, 1, 1);
    set_ch(1, 1, 3'd4, 1, 3'd7, 1, 1);
    m_s1 = 1'b0; m_s2 = 1'b0;
    model_state_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare("R1");
      chk("R1", "cur lf in reset", o_lf[0], 1'b0);
      chk("R1", "vlt bist in reset", o_bist[1], 1'b0);
    end
    rst_n = 1'b1;
    run(1030, "R1");
  endtask

  // R2 / R3: slow chopper table including aliased codes
  task automatic t_lf_table();
    for (int k = 0; k < 8; k++) begin
      set_ch(0, 1, 3'(k), 0, 3'd0, 0, 0);
      set_ch(1, 1, 3'(7 - k), 0, 3'd0, 0, 0);
      run(2048, (k >= 5) ? "R3" : "R2");
    end
  endtask

  // R4 / R5: fast chopper table including aliased codes
  task automatic t_hf_table();
    for (int k = 0; k < 8; k++) begin
      set_ch(0, 0, 3'd0, 1, 3'(k), 0, 0);
      set_ch(1, 0, 3'd0, 1, 3'(7 - k), 0, 0);
      run(2048, (k < 2) ? "R5" : "R4");
    end
  endtask

  // R6: mid-period code change waits for the wrap
  task automatic t_switch();
    int rises;
    logic prev;
    set_ch(0, 1, 3'd0, 1, 3'd2, 0, 0);
    set_ch(1, 1, 3'd0, 1, 3'd2, 0, 0);
    run(1100, "R6");
    wait_cnt(10'd500, "R6");
    set_ch(0, 1, 3'd4, 1, 3'd7, 0, 0);
    rises = 0;
    prev  = o_lf[0];
    while (m_cnt != 10'd0) begin
      tick("R6");
      if (o_lf[0] && !prev) rises++;
      prev = o_lf[0];
    end
    chk("R6", "one old-rate rise before wrap", rises == 1, 1'b1);
    rises = 0;
    for (int i = 0; i < 1024; i++) begin
      tick("R6");
      if (o_lf[0] && !prev) rises++;
      prev = o_lf[0];
    end
    chk("R6", "sixteen new-rate rises after wrap", rises == 16, 1'b1);
  endtask

  // R7: enables gate immediately without disturbing the count
  task automatic t_enables();
    set_ch(0, 1, 3'd4, 1, 3'd6, 1, 0);
    set_ch(1, 1, 3'd3, 1, 3'd5, 1, 0);
    for (int i = 0; i < 40; i++) begin
      en_lf[0]  = i[0];
      en_hf[1]  = i[1];
      en_prs[0] = i[2] ^ i[0];
      en_hf[0]  = ~i[0];
      tick("R7");
      run(36, "R7");
    end
  endtask

  // R8 / R10: dither register advances regardless of enable; channels differ
  task automatic t_dither();
    int diffs;
    set_ch(0, 0, 3'd0, 0, 3'd0, 0, 0);
    set_ch(1, 0, 3'd0, 0, 3'd0, 0, 0);
    run(300, "R8");
    en_prs[0] = 1'b1; en_prs[1] = 1'b1;
    diffs = 0;
    for (int i = 0; i < 500; i++) begin
      tick("R8");
      if (o_prs[0] != o_prs[1]) diffs++;
    end
    chk("R10", "dither streams differ", diffs > 0, 1'b1);
    en_prs[1] = 1'b0;
    set_ch(1, 1, 3'd1, 1, 3'd6, 0, 0);
    run(200, "R10");
  endtask

  // R9: self-test toggle follows the ungated slow chopper
  task automatic t_bist();
    int flips;
    logic prev;
    set_ch(0, 0, 3'd4, 0, 3'd0, 0, 1);
    set_ch(1, 1, 3'd2, 0, 3'd0, 0, 1);
    run(1100, "R9");
    wait_cnt(10'd0, "R9");
    flips = 0;
    prev  = o_bist[0];
    for (int i = 0; i < 640; i++) begin
      tick("R9");
      if (o_bist[0] != prev) flips++;
      prev = o_bist[0];
    end
    chk("R9", "ten toggles in 640 clocks at 64-clock rate", flips == 10, 1'b1);
    en_bist[0] = 1'b0;
    run(150, "R9");
    en_bist[0] = 1'b1;
    en_bist[1] = 1'b0;
    run(600, "R9");
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lf_table();
    t_hf_table();
    t_switch();
    t_enables();
    t_dither();
    t_bist();
    done = 1;
    summary();
    $finish;
  end

endmodule